// File: doc/BRIEF.md
# Chained-Descriptor Receive DMA Engine

This block takes bytes from a serial receiver and stores them in system memory, one buffer at a time. The buffers are described by a linked list of descriptors kept in memory. For each descriptor the engine reads the next-descriptor link, the buffer pointer and the buffer length. It fills the buffer with received bytes, writing 16-bit words where alignment allows. It then stores the number of bytes received and a status byte back into the descriptor, and follows the link to the next descriptor.

Every descriptor address is 24 bits wide. Its upper byte is a programmable chain base and its lower 16 bits are an offset. Software also programs an end-of-chain offset. When the engine is about to use the descriptor at that offset, it halts: it reports an overflow and refuses further receive data until software writes a new end offset. An end-of-frame marker on the receive stream closes the current buffer early and flags the descriptor.

Top module: `rx_chain_dma`

## Requirements
- R1: Each descriptor access uses the byte address {chain base, offset}, where the 16-bit offset is the current descriptor offset plus the field offset. The fetch is four 16-bit reads, each with both strobes set, at offsets +0, +2, +4 and +6. Fields are little-endian: +0..+1 holds the next-descriptor offset, +2..+4 the 24-bit buffer pointer, +5 the status byte and +6..+7 the buffer length. The register select codes are 0 for the chain base (low 8 data bits), 1 for the current offset, 2 for the end offset and 3 for control (bit 0 enables the engine).
- R2: Data is written starting at the buffer pointer, at consecutive byte addresses. No byte is written past the end of the frame's data.
- R3: A 16-bit write (strobes 2'b11, low byte at the even address) is used only when the address is even, at least 2 bytes remain in the buffer and two received bytes are held. Otherwise a single byte is written: strobe 2'b01 with the data on bits 7:0 for an even address, or strobe 2'b10 with the data on bits 15:8 for an odd address.
- R4: When the remaining count reaches zero, the buffer is closed. The descriptor's length field receives the number of bytes stored, and its status byte receives 0x00 if no end-of-frame was seen.
- R5: A byte accepted with end-of-frame closes the buffer after that byte is stored. The stored length is the actual count, status bit 7 is set (0x80), and irq_frame pulses high for exactly one cycle.
- R6: After the write-back, the current offset takes the next-descriptor offset, and the next fetch reads from that descriptor.
- R7: If the current offset equals the end offset when a descriptor would be started, the engine halts. irq_ovf stays high and rx_ready stays low until the end offset is written, after which the engine resumes from the current descriptor.
- R8: A memory request holds its address, direction and strobes unchanged until mem_ack is seen.
- R9: After reset, mem_req, rx_ready, irq_frame and irq_ovf are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_eof | input | 1 | Offered byte is the last of its frame |
| rx_ready | output | 1 | Engine accepts the offered byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Byte strobes, bit 0 for the even byte |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| irq_frame | output | 1 | One-cycle pulse when a frame's last buffer is closed |
| irq_ovf | output | 1 | Halted at the end-of-chain descriptor |

## Verification
The main sweep covers three things: buffer start parity (even or odd), buffer length from 1 to 4 and frame length from 1 to 6. Memory latency is varied alongside them. Start parity tells correct word/byte selection from plain byte-by-byte transfer. Frame lengths below, equal to and above a multiple of the buffer length tell an early end-of-frame close apart from a count-exhausted close, including the case where both happen on the same byte. A separate run stops the chain at the end offset, then moves the end offset and resumes, which separates a true halt from a stall.

// File: rtl/rx_dma_pkg.sv
// Package: shared state encoding and descriptor layout for the chained
// receive DMA. Assumes 16-bit memory data with two byte lanes.
package rx_dma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_XFER,
        S_WBACK,
        S_NEXT,
        S_HALT
    } dma_state_t;

    // Descriptor field offsets (bytes from descriptor start)
    localparam int DESC_BYTES    = 8;
    localparam int OFS_LINK      = 0;
    localparam int OFS_STATUS    = 5;
    localparam int OFS_LEN       = 6;
    localparam int STAT_EOF_BIT  = 7;

    // Register select codes
    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_CUR  = 2'd1;
    localparam logic [1:0] SEL_END  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/rx_dma_regs.sv
// Module: rx_dma_regs
// Holds the chain base, current descriptor offset, end-of-chain offset and
// the enable bit. Software writes through a select/data port; the engine
// reloads the current offset when it follows a link, and that reload takes
// priority over a software write in the same cycle.
// Assumes OFS_W >= BASE_W so the base fits in the write data.
module rx_dma_regs
    import rx_dma_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int BASE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [OFS_W-1:0]  reg_wdata,
    input  logic              cur_load,
    input  logic [OFS_W-1:0]  cur_next,
    output logic [BASE_W-1:0] base_o,
    output logic [OFS_W-1:0]  cur_o,
    output logic [OFS_W-1:0]  end_o,
    output logic              enable_o,
    output logic              end_wr_o
);

    // Register storage with engine priority on the current offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o   <= '0;
            cur_o    <= '0;
            end_o    <= '0;
            enable_o <= 1'b0;
        end else begin
            if (reg_we && reg_sel == SEL_BASE) base_o <= reg_wdata[BASE_W-1:0];
            if (reg_we && reg_sel == SEL_END)  end_o  <= reg_wdata;
            if (reg_we && reg_sel == SEL_CTRL) enable_o <= reg_wdata[0];
            if (cur_load)
                cur_o <= cur_next;
            else if (reg_we && reg_sel == SEL_CUR)
                cur_o <= reg_wdata;
        end
    end

    // Pulse telling the engine that the end offset was rewritten
    always_comb end_wr_o = reg_we && (reg_sel == SEL_END);

endmodule

// File: rtl/rx_dma_pack.sv
// Module: rx_dma_pack
// Collects up to two received bytes before a memory write and remembers
// whether the last accepted byte carried end-of-frame. It accepts bytes
// only while the controller allows it, fewer than 'want' bytes are held,
// and no end-of-frame is pending. A clear empties it after the write.
module rx_dma_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take_en,
    input  logic [1:0] want,
    input  logic       clr,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_eof,
    output logic       rx_ready,
    output logic [1:0] nheld,
    output logic [7:0] byte0,
    output logic [7:0] byte1,
    output logic       eof_seen
);

    // Readiness: room left for the current write and no frame end pending
    always_comb rx_ready = take_en && !eof_seen && (nheld < want);

    // Byte capture and end-of-frame tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nheld    <= 2'd0;
            byte0    <= 8'h00;
            byte1    <= 8'h00;
            eof_seen <= 1'b0;
        end else if (clr) begin
            nheld    <= 2'd0;
            eof_seen <= 1'b0;
        end else if (rx_valid && rx_ready) begin
            if (nheld == 2'd0) byte0 <= rx_data;
            else               byte1 <= rx_data;
            nheld    <= nheld + 2'd1;
            eof_seen <= rx_eof;
        end
    end

endmodule

// File: rtl/rx_dma_ctrl.sv
// Module: rx_dma_ctrl
// Sequencer and memory master. It fetches a descriptor (four word reads),
// transfers received data into the buffer with word or byte writes, writes
// the length and status back, then follows the link. It halts when the
// current offset equals the end offset. Every access holds its request
// until acknowledge. Assumes 16 < ADDR_W <= 32 and 16-bit memory data.
module rx_dma_ctrl
    import rx_dma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-OFS_W-1:0]  base,
    input  logic [OFS_W-1:0]         cur,
    input  logic [OFS_W-1:0]         end_ofs,
    input  logic                     enable,
    input  logic                     end_wr,
    output logic                     cur_load,
    output logic [OFS_W-1:0]         cur_next,
    input  logic [1:0]               nheld,
    input  logic [7:0]               byte0,
    input  logic [7:0]               byte1,
    input  logic                     eof_seen,
    output logic [1:0]               want,
    output logic                     take_en,
    output logic                     pack_clr,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [15:0]              mem_wdata,
    output logic [1:0]               mem_be,
    input  logic [15:0]              mem_rdata,
    input  logic                     mem_ack,
    output logic                     irq_frame,
    output logic                     irq_ovf
);

    localparam int HI_W = ADDR_W - 16;

    dma_state_t          state;
    logic [1:0]          phase;
    logic [OFS_W-1:0]    link;
    logic [ADDR_W-1:0]   bar;
    logic [CNT_W-1:0]    bcr;
    logic [CNT_W-1:0]    rcvd;
    logic                frame_end;
    logic                wr_go;
    logic [OFS_W-1:0]    fld_ofs;
    logic [ADDR_W-1:0]   desc_addr;
    logic                done;

    // Word write only on even address with two or more bytes left
    always_comb want = (!bar[0] && bcr >= CNT_W'(2)) ? 2'd2 : 2'd1;

    // A data write is ready when the pair is complete or the frame ended
    always_comb wr_go = (state == S_XFER) && (bcr != '0) &&
                        ((nheld == want) || (eof_seen && nheld != 2'd0));

    // Receive intake is open only while a buffer has room
    always_comb take_en = (state == S_XFER) && (bcr != '0);

    // Field offset inside the descriptor for fetch and write-back
    always_comb begin
        if (state == S_FETCH)
            fld_ofs = OFS_W'({phase, 1'b0});
        else if (phase == 2'd0)
            fld_ofs = OFS_W'(OFS_LEN);
        else
            fld_ofs = OFS_W'(OFS_STATUS);
    end

    // Full descriptor byte address from base and offset
    always_comb desc_addr = {base, cur + fld_ofs};

    // Memory master outputs decoded from state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = 16'h0000;
        mem_be    = 2'b11;
        case (state)
            S_FETCH: mem_req = 1'b1;
            S_XFER: begin
                mem_req  = wr_go;
                mem_we   = 1'b1;
                mem_addr = bar;
                if (nheld == 2'd2) begin
                    mem_wdata = {byte1, byte0};
                    mem_be    = 2'b11;
                end else if (bar[0]) begin
                    mem_wdata = {byte0, 8'h00};
                    mem_be    = 2'b10;
                end else begin
                    mem_wdata = {8'h00, byte0};
                    mem_be    = 2'b01;
                end
            end
            S_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (phase == 2'd0) begin
                    mem_wdata = 16'(rcvd);
                    mem_be    = 2'b11;
                end else begin
                    mem_wdata = {frame_end, 7'b0, 8'h00};
                    mem_be    = 2'b10;
                end
            end
            default: ;
        endcase
    end

    // Access completion
    always_comb done = mem_req && mem_ack;

    // Pack buffer empties when its data write completes
    always_comb pack_clr = (state == S_XFER) && done;

    // Link follow and interrupts
    always_comb begin
        cur_load  = (state == S_NEXT);
        cur_next  = link;
        irq_frame = (state == S_NEXT) && frame_end;
        irq_ovf   = (state == S_HALT);
    end

    // Main sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            phase     <= 2'd0;
            link      <= '0;
            bar       <= '0;
            bcr       <= '0;
            rcvd      <= '0;
            frame_end <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (enable) begin
                        phase     <= 2'd0;
                        frame_end <= 1'b0;
                        state     <= (cur == end_ofs) ? S_HALT : S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (done) begin
                        phase <= phase + 2'd1;
                        case (phase)
                            2'd0: link <= mem_rdata[OFS_W-1:0];
                            2'd1: bar[15:0] <= mem_rdata;
                            2'd2: bar[ADDR_W-1:16] <= mem_rdata[HI_W-1:0];
                            default: begin
                                bcr   <= CNT_W'(mem_rdata);
                                rcvd  <= '0;
                                state <= S_XFER;
                            end
                        endcase
                    end
                end
                S_XFER: begin
                    if (done) begin
                        bar  <= bar + ADDR_W'(nheld);
                        bcr  <= bcr - CNT_W'(nheld);
                        rcvd <= rcvd + CNT_W'(nheld);
                        if (eof_seen) begin
                            frame_end <= 1'b1;
                            phase     <= 2'd0;
                            state     <= S_WBACK;
                        end
                    end else if (bcr == '0) begin
                        phase <= 2'd0;
                        state <= S_WBACK;
                    end
                end
                S_WBACK: begin
                    if (done) begin
                        if (phase == 2'd0) phase <= 2'd1;
                        else               state <= S_NEXT;
                    end
                end
                S_NEXT: state <= S_IDLE;
                S_HALT: if (end_wr) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_chain_dma.sv
// Module: rx_chain_dma (top)
// Chained-descriptor receive DMA: register block, byte pairing stage and
// sequencer/memory master. Memory is byte addressed with a 16-bit data
// path; strobe bit 0 selects the even byte. All state resets synchronously
// on rst_n low.
module rx_chain_dma #(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_eof,
    output logic              rx_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic [1:0]        mem_be,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [OFS_W-1:0]  reg_wdata,
    output logic              irq_frame,
    output logic              irq_ovf
);

    localparam int BASE_W = ADDR_W - OFS_W;

    logic [BASE_W-1:0] base;
    logic [OFS_W-1:0]  cur;
    logic [OFS_W-1:0]  end_ofs;
    logic              enable;
    logic              end_wr;
    logic              cur_load;
    logic [OFS_W-1:0]  cur_next;
    logic [1:0]        nheld;
    logic [7:0]        byte0;
    logic [7:0]        byte1;
    logic              eof_seen;
    logic [1:0]        want;
    logic              take_en;
    logic              pack_clr;

    rx_dma_regs #(.OFS_W(OFS_W), .BASE_W(BASE_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .cur_load(cur_load), .cur_next(cur_next),
        .base_o(base), .cur_o(cur), .end_o(end_ofs),
        .enable_o(enable), .end_wr_o(end_wr)
    );

    rx_dma_pack i_pack (
        .clk(clk), .rst_n(rst_n),
        .take_en(take_en), .want(want), .clr(pack_clr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof),
        .rx_ready(rx_ready), .nheld(nheld),
        .byte0(byte0), .byte1(byte1), .eof_seen(eof_seen)
    );

    rx_dma_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .base(base), .cur(cur), .end_ofs(end_ofs),
        .enable(enable), .end_wr(end_wr),
        .cur_load(cur_load), .cur_next(cur_next),
        .nheld(nheld), .byte0(byte0), .byte1(byte1), .eof_seen(eof_seen),
        .want(want), .take_en(take_en), .pack_clr(pack_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .irq_frame(irq_frame), .irq_ovf(irq_ovf)
    );

endmodule

// File: rtl/rx_chain_dma_chk.sv
// Module: rx_chain_dma_chk
// Protocol checker bound to the top module: request holding, write lane
// rules, read alignment, halt behaviour and frame interrupt pulse width.
module rx_chain_dma_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_be,
    input logic              rx_ready,
    input logic              irq_ovf,
    input logic              irq_frame
);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be));

    // R3
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_be == 2'b11 |-> !mem_addr[0]);

    // R3
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && $countones(mem_be) == 1 |-> mem_be[1] == mem_addr[0]);

    // R1
    read_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_be == 2'b11 && !mem_addr[0]);

    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> !rx_ready && !mem_req);

    // R5
    frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_frame |=> !irq_frame);

endmodule

bind rx_chain_dma rx_chain_dma_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be),
    .rx_ready(rx_ready), .irq_ovf(irq_ovf), .irq_frame(irq_frame)
);

// File: tb/test_rx_chain_dma.sv
// Bench: sweeps buffer parity, buffer length, frame length and memory
// latency, then checks memory contents and descriptor write-backs against
// values computed here; a second run exercises the end-of-chain halt.
module test_rx_chain_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_eof = 1'b0;
    logic        rx_ready;
    logic        mem_req;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [1:0]  mem_be;
    logic [15:0] mem_rdata;
    logic        mem_ack;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0000;
    logic        irq_frame;
    logic        irq_ovf;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int delay = 0;
    int wcnt = 0;
    int addr_bad = 0;
    int word_cnt = 0;
    int frame_cnt = 0;
    logic [15:0] last_fetch = 16'h0;
    logic [7:0] mem [0:4095];

    localparam logic [7:0] BASE = 8'h5A;
    localparam logic [7:0] BPHI = 8'h3C;

    always #10 clk = ~clk;

    rx_chain_dma i_rx_chain_dma (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof), .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .irq_frame(irq_frame), .irq_ovf(irq_ovf)
    );

    assign mem_rdata = {mem[{mem_addr[11:1], 1'b1}], mem[{mem_addr[11:1], 1'b0}]};

    // Memory model with programmable acknowledge latency, plus monitors
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                if (wcnt >= delay) begin
                    mem_ack <= 1'b1;
                    wcnt    <= 0;
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    if (mem_be[0]) mem[{mem_addr[11:1], 1'b0}] <= mem_wdata[7:0];
                    if (mem_be[1]) mem[{mem_addr[11:1], 1'b1}] <= mem_wdata[15:8];
                    if (mem_be == 2'b11 && mem_addr[11:8] >= 4'h4) word_cnt <= word_cnt + 1;
                end else if (mem_addr[2:0] == 3'd0) begin
                    last_fetch <= mem_addr[15:0];
                end
                if (mem_addr[15:8] == 8'h01) begin
                    if (mem_addr[23:16] != BASE) addr_bad <= addr_bad + 1;
                end else if (mem_addr[23:16] != BPHI) begin
                    addr_bad <= addr_bad + 1;
                end
            end
            if (irq_frame) frame_cnt <= frame_cnt + 1;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx_valid = 1'b0;
        rx_eof = 1'b0;
        reg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        addr_bad = 0;
        word_cnt = 0;
        frame_cnt = 0;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        reg_we = 1'b1;
        reg_sel = sel;
        reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic e);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data = d;
        rx_eof = e;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        rx_eof = 1'b0;
    endtask

    // Build 8 chained descriptors at 0x100 + 8*i, buffers at 0x400 + 16*i
    task automatic build_chain(input int odd, input int blen);
        for (int a = 0; a < 4096; a++) mem[a] = 8'hEE;
        for (int d = 0; d < 8; d++) begin
            int da = 'h100 + 8 * d;
            int bp = 'h400 + 16 * d + odd;
            int nx = 'h100 + 8 * (d + 1);
            mem[da + 0] = nx[7:0];
            mem[da + 1] = nx[15:8];
            mem[da + 2] = bp[7:0];
            mem[da + 3] = bp[15:8];
            mem[da + 4] = BPHI;
            mem[da + 5] = 8'h55;
            mem[da + 6] = blen[7:0];
            mem[da + 7] = 8'h00;
        end
    endtask

    function automatic logic [7:0] pat(input int j, input int t);
        return 8'((j * 7 + t * 3 + 1) & 255);
    endfunction

    task automatic run_trial(input int odd, input int blen, input int flen, input int t);
        int k;
        int exp_words;
        int j;
        build_chain(odd, blen);
        delay = (flen + blen) % 3;
        do_reset();
        reg_write(2'd0, {8'h00, BASE});
        reg_write(2'd1, 16'h0100);
        reg_write(2'd2, 16'h0140);
        reg_write(2'd3, 16'h0001);
        for (int i = 0; i < flen; i++) send_byte(pat(i, t), i == flen - 1);
        repeat (60) @(negedge clk);
        k = (flen + blen - 1) / blen;
        // R2 data placement at consecutive addresses from each buffer pointer
        for (int i = 0; i < flen; i++)
            check($sformatf("R2 data t%0d byte%0d", t, i),
                  mem['h400 + 16 * (i / blen) + odd + (i % blen)], pat(i, t));
        // R2 nothing past the frame's last byte
        check($sformatf("R2 no overrun t%0d", t),
              mem['h400 + 16 * (k - 1) + odd + (flen - (k - 1) * blen)], 8'hEE);
        // R4 and R5 write-back of length and status
        for (int b = 0; b < k; b++) begin
            int da = 'h100 + 8 * b;
            int ln = (b == k - 1) ? flen - b * blen : blen;
            check($sformatf("R4/R5 len t%0d desc%0d", t, b), {mem[da + 7], mem[da + 6]}, ln);
            check($sformatf("R4/R5 status t%0d desc%0d", t, b), mem[da + 5],
                  (b == k - 1) ? 8'h80 : 8'h00);
        end
        check($sformatf("R4 untouched t%0d", t), mem['h100 + 8 * k + 5], 8'h55);
        // R5 one frame interrupt per frame
        check($sformatf("R5 irq_frame count t%0d", t), frame_cnt, 1);
        // R3 word write count from the alignment rule
        exp_words = 0;
        j = 0;
        while (j < flen) begin
            int pos = j % blen;
            if (((odd + pos) % 2 == 0) && (blen - pos >= 2) && (flen - j >= 2)) begin
                exp_words++;
                j += 2;
            end else begin
                j += 1;
            end
        end
        check($sformatf("R3 word writes t%0d", t), word_cnt, exp_words);
        // R1 address upper byte from base or buffer pointer
        check($sformatf("R1 addr base t%0d", t), addr_bad, 0);
        // R6 chain followed to the descriptor after the last used one
        check($sformatf("R6 next fetch t%0d", t), last_fetch, 'h100 + 8 * k);
        check($sformatf("R6 ready for more t%0d", t), {irq_ovf, rx_ready}, 2'b01);
    endtask

    initial begin
        int t;
        // R9 reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 mem_req", mem_req, 0);
        check("R9 rx_ready", rx_ready, 0);
        check("R9 irq_frame", irq_frame, 0);
        check("R9 irq_ovf", irq_ovf, 0);

        t = 0;
        for (int odd = 0; odd < 2; odd++)
            for (int blen = 1; blen <= 4; blen++)
                for (int flen = 1; flen <= 6; flen++) begin
                    run_trial(odd, blen, flen, t);
                    t++;
                end

        // R7 halt at end-of-chain descriptor, then resume
        build_chain(0, 2);
        delay = 1;
        do_reset();
        reg_write(2'd0, {8'h00, BASE});
        reg_write(2'd1, 16'h0100);
        reg_write(2'd2, 16'h0110);
        reg_write(2'd3, 16'h0001);
        for (int i = 0; i < 4; i++) send_byte(pat(i, 99), 1'b0);
        repeat (40) @(negedge clk);
        check("R7 irq_ovf high", irq_ovf, 1);
        check("R7 rx_ready low", rx_ready, 0);
        check("R7 no frame irq", frame_cnt, 0);
        check("R4 len desc1", {mem['h10F], mem['h10E]}, 2);
        check("R4 status desc1", mem['h10D], 8'h00);
        check("R7 halted desc untouched", mem['h115], 8'h55);
        reg_write(2'd2, 16'h0128);
        repeat (30) @(negedge clk);
        check("R7 irq_ovf cleared", irq_ovf, 0);
        check("R7 rx_ready resumed", rx_ready, 1);
        send_byte(8'hA7, 1'b1);
        repeat (30) @(negedge clk);
        check("R7 resumed data", mem['h420], 8'hA7);
        check("R5 resumed len", {mem['h117], mem['h116]}, 1);
        check("R5 resumed status", mem['h115], 8'h80);
        check("R5 resumed irq", frame_cnt, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule